// File: doc/BRIEF.md
# Serial Port Host Register Front End

This block is the register-side front end of a 16550-compatible serial port. The host reaches it over a simple byte-wide bus that carries a three-bit offset, a write strobe and a read strobe. A divisor-latch access input selects which registers those offsets reach. The block routes reads of the data offset to the receive byte that the receive path supplies. It latches writes of the data offset into a transmit holding byte and raises a push strobe. It also keeps the interrupt enable bits.

The FIFO control register is write-only. It shares its offset with the interrupt identification value, which the interrupt logic supplies and which a read of that offset returns. Every byte written to the FIFO control register is also copied into a shadow register, and a dedicated output lets that copy be read. Bit 0 of the written byte sets the FIFO enable output. Writing 0 to that bit raises a one-cycle FIFO clear strobe. Four pending-interrupt flags come in from the rest of the port. They are masked by the enable bits and combined into one interrupt line.

Top module: `uart_host_regs`

## Requirements
- R1: When the offset is 0 and divisor-latch access is 0, rd_data equals rx_data, and rx_pop equals host_rd in the same cycle. rx_pop is 0 in every other case.
- R2: A write at offset 0 with divisor-latch access 0 loads wdata into tx_data at the clock edge. tx_push is then 1 for exactly the following cycle.
- R3: At offset 1 with divisor-latch access 0, a write stores wdata[3:0] as the interrupt enable bits. A read returns those bits in rd_data[3:0], and rd_data[7:4] always reads 0.
- R4: With divisor-latch access 1, offsets 0 and 1 read as 0. Writes to them change neither tx_data nor the enable bits, and they raise no tx_push. Reads raise no rx_pop.
- R5: irq is 1 exactly when some bit i has both pend[i] and enable bit i set. Bit 0 is receive data or timeout, bit 1 is transmit holding empty, bit 2 is line status and bit 3 is modem status change.
- R6: When all four enable bits are 0, irq stays 0 whatever pend holds.
- R7: A read at offset 2 returns iid_in whatever the divisor-latch access value. A write at offset 2 reaches the FIFO control register whatever that value is.
- R8: fifo_en equals bit 0 of the byte most recently written at offset 2.
- R9: A write at offset 2 with wdata[0]=0 makes fifo_clr 1 for exactly the following cycle. This covers the automatic flush when FIFO mode is left. A write with wdata[0]=1 raises no fifo_clr.
- R10: fcr_shadow equals the whole byte most recently written at offset 2.
- R11: While rst is high at a clock edge, the enable bits, fifo_en, fcr_shadow, tx_data, tx_push and fifo_clr all clear to 0. As a result irq is 0 after reset.
- R12: Offsets 3 to 7 read as 0. Writes to them change none of the block's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register offset |
| dlab | input | 1 | Divisor-latch access select |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register |
| rx_data | input | 8 | Receive byte offered by the receive path |
| rx_pop | output | 1 | Receive byte consumed this cycle |
| tx_data | output | 8 | Transmit holding byte |
| tx_push | output | 1 | Transmit holding byte newly loaded |
| iid_in | input | 8 | Interrupt identification value |
| pend | input | 4 | Pending interrupt flags |
| irq | output | 1 | Combined interrupt |
| fifo_en | output | 1 | FIFO mode enable |
| fifo_clr | output | 1 | Clear both FIFOs |
| fcr_shadow | output | 8 | Read-back copy of the FIFO control byte |

## Verification
The assertions check the following on every cycle: that rx_pop comes only from a data-offset read with latch access off, that tx_push follows a data-offset write and nothing else, that the upper enable bits read as zero, that irq is never raised without a pending flag, and that an offset-2 write sets fifo_en, the shadow and the clear strobe on the next cycle. Only the bench scenarios show the full enable-by-pending truth table of irq, the masking of writes while latch access is 1 and at the unused offsets, and how the enable bits, shadow and FIFO mode stay put across later unrelated traffic and clear on reset.

// File: rtl/uart_host_regs.sv
module uart_host_regs #(
  parameter int AW   = 3,
  parameter int DW   = 8,
  parameter int NSRC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          dlab,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] rx_data,
  output logic          rx_pop,
  output logic [DW-1:0] tx_data,
  output logic          tx_push,
  input  logic [DW-1:0] iid_in,
  input  logic [NSRC-1:0] pend,
  output logic          irq,
  output logic          fifo_en,
  output logic          fifo_clr,
  output logic [DW-1:0] fcr_shadow
);
  localparam logic [AW-1:0] OFF_DATA = AW'(0);
  localparam logic [AW-1:0] OFF_IEN  = AW'(1);
  localparam logic [AW-1:0] OFF_FCTL = AW'(2);

  logic [NSRC-1:0] ier_q;
  logic sel_data, sel_ien, sel_fctl;

  assign sel_data = (addr == OFF_DATA) && !dlab;
  assign sel_ien  = (addr == OFF_IEN)  && !dlab;
  assign sel_fctl = (addr == OFF_FCTL);

  assign rx_pop = host_rd && sel_data;
  assign irq    = |(pend & ier_q);

  always_comb begin
    rd_data = '0;
    if (sel_data)      rd_data = rx_data;
    else if (sel_ien)  rd_data = {{(DW-NSRC){1'b0}}, ier_q};
    else if (sel_fctl) rd_data = iid_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q      <= '0;
      tx_data    <= '0;
      tx_push    <= 1'b0;
      fifo_en    <= 1'b0;
      fifo_clr   <= 1'b0;
      fcr_shadow <= '0;
    end else begin
      tx_push  <= host_wr && sel_data;
      fifo_clr <= host_wr && sel_fctl && !wdata[0];
      if (host_wr && sel_data) tx_data <= wdata;
      if (host_wr && sel_ien)  ier_q   <= wdata[NSRC-1:0];
      if (host_wr && sel_fctl) begin
        fifo_en    <= wdata[0];
        fcr_shadow <= wdata;
      end
    end
  end
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk #(
  parameter int AW   = 3,
  parameter int DW   = 8,
  parameter int NSRC = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic          dlab,
  input logic          host_wr,
  input logic          host_rd,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rd_data,
  input logic          rx_pop,
  input logic [DW-1:0] tx_data,
  input logic          tx_push,
  input logic [NSRC-1:0] pend,
  input logic          irq,
  input logic          fifo_en,
  input logic          fifo_clr,
  input logic [DW-1:0] fcr_shadow
);
  p_pop_src_r1: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> (host_rd && addr == AW'(0) && !dlab));

  p_push_load_r2: assert property (@(posedge clk) disable iff (rst)
    (host_wr && addr == AW'(0) && !dlab) |=> (tx_push && tx_data == $past(wdata)));

  p_push_src_r2: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && addr == AW'(0) && !dlab) |=> !tx_push);

  p_ien_high_r3: assert property (@(posedge clk) disable iff (rst)
    (addr == AW'(1) && !dlab) |-> (rd_data[DW-1:NSRC] == '0));

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend != '0));

  p_fctl_write_r8: assert property (@(posedge clk) disable iff (rst)
    (host_wr && addr == AW'(2)) |=> (fcr_shadow == $past(wdata) && fifo_en == $past(wdata[0])));

  p_flush_r9: assert property (@(posedge clk) disable iff (rst)
    (host_wr && addr == AW'(2) && !wdata[0]) |=> (fifo_clr && !fifo_en));

  p_flush_src_r9: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && addr == AW'(2) && !wdata[0]) |=> !fifo_clr);
endmodule

bind uart_host_regs uart_host_regs_chk #(.AW(AW), .DW(DW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .dlab(dlab), .host_wr(host_wr),
  .host_rd(host_rd), .wdata(wdata), .rd_data(rd_data), .rx_pop(rx_pop),
  .tx_data(tx_data), .tx_push(tx_push), .pend(pend), .irq(irq),
  .fifo_en(fifo_en), .fifo_clr(fifo_clr), .fcr_shadow(fcr_shadow)
);

// File: tb/uart_host_regs_bench.sv
module uart_host_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, dlab, host_wr, host_rd, rx_pop, tx_push, irq, fifo_en, fifo_clr;
  logic [2:0] addr;
  logic [7:0] wdata, rd_data, rx_data, tx_data, iid_in, fcr_shadow;
  logic [3:0] pend;

  int nvec = 0;
  int nfail = 0;
  logic [7:0] exp_tx;
  logic [3:0] exp_ien;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_host_regs u_uart_host_regs (
    .clk(clk), .rst(rst), .addr(addr), .dlab(dlab), .host_wr(host_wr),
    .host_rd(host_rd), .wdata(wdata), .rd_data(rd_data), .rx_data(rx_data),
    .rx_pop(rx_pop), .tx_data(tx_data), .tx_push(tx_push), .iid_in(iid_in),
    .pend(pend), .irq(irq), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
    .fcr_shadow(fcr_shadow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic dl);
    @(negedge clk);
    addr = a; wdata = d; dlab = dl; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic dl);
    @(negedge clk);
    addr = a; dlab = dl; host_rd = 1'b1;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_tx = 8'h00; exp_ien = 4'h0;
  endtask

  task automatic check_reset();
    pend = 4'hF;
    #1;
    chk("R11 fifo_en", fifo_en, 0);
    chk("R11 fcr_shadow", fcr_shadow, 0);
    chk("R11 tx_data", tx_data, 0);
    chk("R11 tx_push", tx_push, 0);
    chk("R11 fifo_clr", fifo_clr, 0);
    chk("R11 irq", irq, 0);
    rd(3'd1, 1'b0);
    chk("R11 enable bits", rd_data, 0);
    host_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; dlab = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    addr = '0; wdata = '0; rx_data = '0; iid_in = '0; pend = '0;
    do_reset();
    check_reset();

    for (int v = 0; v < 256; v += 51) begin
      rx_data = 8'(v ^ 8'h3C);
      rd(3'd0, 1'b0);
      chk("R1 rd_data", rd_data, 8'(v ^ 8'h3C));
      chk("R1 rx_pop", rx_pop, 1);
      host_rd = 1'b0; #1;
      chk("R1 rx_pop idle", rx_pop, 0);
      rd(3'd0, 1'b1);
      chk("R4 data read dlab", rd_data, 0);
      chk("R4 rx_pop dlab", rx_pop, 0);
      host_rd = 1'b0;
    end

    foreach (exp_tx[i]) begin
      logic [7:0] d;
      d = 8'h01 << i ^ 8'hA5;
      wr(3'd0, d, 1'b0);
      chk("R2 tx_data", tx_data, d);
      chk("R2 tx_push", tx_push, 1);
      @(negedge clk);
      chk("R2 tx_push single", tx_push, 0);
      exp_tx = d;
    end

    for (int v = 0; v < 256; v++) begin
      wr(3'd1, 8'(v), 1'b0);
      rd(3'd1, 1'b0);
      chk("R3 enable readback", rd_data, v & 8'h0F);
      host_rd = 1'b0;
    end

    wr(3'd1, 8'h0A, 1'b0);
    wr(3'd1, 8'hFF, 1'b1);
    chk("R4 dlab ien no push", tx_push, 0);
    rd(3'd1, 1'b1);
    chk("R4 ien read dlab", rd_data, 0);
    rd(3'd1, 1'b0);
    chk("R4 ien unchanged", rd_data, 8'h0A);
    host_rd = 1'b0;
    wr(3'd0, 8'h77, 1'b1);
    chk("R4 tx_push dlab", tx_push, 0);
    chk("R4 tx_data kept", tx_data, exp_tx);

    for (int e = 0; e < 16; e++) begin
      wr(3'd1, 8'(e), 1'b0);
      for (int p = 0; p < 16; p++) begin
        pend = 4'(p); #1;
        if (e == 0) chk("R6 irq masked", irq, 0);
        else        chk("R5 irq", irq, ((e & p) != 0) ? 1 : 0);
      end
    end
    pend = 4'h0;

    for (int v = 0; v < 256; v += 37) begin
      iid_in = 8'(v);
      rd(3'd2, 1'b0);
      chk("R7 iid dlab0", rd_data, v);
      rd(3'd2, 1'b1);
      chk("R7 iid dlab1", rd_data, v);
      host_rd = 1'b0;
    end

    wr(3'd2, 8'h01, 1'b0);
    chk("R8 fifo_en on", fifo_en, 1);
    chk("R9 no clr", fifo_clr, 0);
    chk("R10 shadow", fcr_shadow, 8'h01);
    wr(3'd2, 8'hC1, 1'b0);
    chk("R10 shadow C1", fcr_shadow, 8'hC1);
    chk("R9 no clr C1", fifo_clr, 0);
    wr(3'd2, 8'h80, 1'b0);
    chk("R8 fifo_en off", fifo_en, 0);
    chk("R9 clr on exit", fifo_clr, 1);
    chk("R10 shadow 80", fcr_shadow, 8'h80);
    @(negedge clk);
    chk("R9 clr single", fifo_clr, 0);
    wr(3'd2, 8'h00, 1'b0);
    chk("R9 clr when off", fifo_clr, 1);
    wr(3'd2, 8'h47, 1'b1);
    chk("R7 fctl write dlab", fifo_en, 1);
    chk("R10 shadow 47", fcr_shadow, 8'h47);
    chk("R9 clr after set", fifo_clr, 0);

    wr(3'd1, 8'h05, 1'b0);
    for (int a = 3; a < 8; a++) begin
      for (int dl = 0; dl < 2; dl++) begin
        rd(3'(a), 1'(dl));
        chk("R12 unused read", rd_data, 0);
        host_rd = 1'b0;
        wr(3'(a), 8'hFE, 1'(dl));
        chk("R12 no push", tx_push, 0);
        chk("R12 no clr", fifo_clr, 0);
        chk("R12 shadow kept", fcr_shadow, 8'h47);
        chk("R12 fifo_en kept", fifo_en, 1);
      end
    end
    rd(3'd1, 1'b0);
    chk("R12 ien kept", rd_data, 8'h05);
    host_rd = 1'b0;

    do_reset();
    check_reset();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule